// File: doc/BRIEF.md
# I/O Translator Control and Fault Register Bank

This block is the 32-bit register bank for an I/O address translator. A host reaches it by word reads and writes at byte offsets. The bank holds these registers:

- translator control
- page-table base
- two flush words
- fault status and fault address
- arbiter enable and arbitration enable
- four per-slot configuration words
- an identification word

Each register applies its own write mask and its own forced bits when it is written. The identification word is different: a write ORs new bits into it instead of replacing it.

On a control write, the block decodes the window-size field into the lowest address of the translation window. It keeps that start address on an output for the translator. The translator reports a fault by pulsing a fault input together with a status word and an address word. The bank stores both words and raises a level interrupt. The interrupt drops when the host reads or writes either fault register.

Top module: `xlat_regbank`

## Requirements
- R1: The register index is the byte offset divided by 4. The register offsets are: control 0x0, base 0x4, full flush 0x14, page flush 0x18, fault status 0x1000, fault address 0x1004, arbiter enable 0x1008, slot configs 0x1010, 0x1014, 0x1018 and 0x101C, arbitration enable 0x2000, identification 0x3018. A read of any other offset returns 0. A write to any other offset changes no register.
- R2: A control write stores (data & 0x1D) with the parameter IMPL_VER in bits 31:24.
- R3: On a control write, data bits 4:2 (code c) set the window start output to 0xFF000000 << c. The window start changes at no other time.
- R4: A base write keeps (data & 0x07FFFC00). Each of the two flush registers stores all 32 bits of the written data.
- R5: A fault status write stores (data & 0xFF0FFFFF) | 0x00800000. A fault address write stores the whole data word. Either write clears the interrupt.
- R6: A read of fault status or fault address clears the interrupt. A read of any other offset leaves the interrupt and all registers unchanged.
- R7: An arbiter enable write stores (data & 0x801F000F) | 0x1. An arbitration enable write stores (data & 0x001F0000) | 0x8. A slot config write stores (data & 0x00010003).
- R8: An identification write sets the bits of (data & 0x00FFFFFF) in that register. It never clears a bit.
- R9: After reset the registers hold these values: control = {IMPL_VER, 24'h0}, fault status = 0x00800000, arbiter enable = 0x3, arbitration enable = 0x8, identification = 0x23000000. Every other register is 0, the window start is 0 and the interrupt is low.
- R10: A fault pulse loads fault status with (status & 0xFF0FFFFF) | 0x00800000 and loads fault address with the supplied address. It sets the interrupt on the same clock edge. If a host access to a fault register falls in the same cycle, the fault pulse decides the contents of both fault registers and the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | AW | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| flt_evt | input | 1 | Fault pulse from the translator |
| flt_status | input | 32 | Fault status word supplied with the pulse |
| flt_addr | input | 32 | Faulting address supplied with the pulse |
| win_start | output | 32 | Lowest address of the translation window |
| irq | output | 1 | Level fault interrupt |

## Verification
The embedded assertions check four things on every cycle:

- a fault pulse raises the interrupt on the next edge;
- a host access to a fault register with no fault pulse in that cycle lowers the interrupt;
- the window start holds still unless the control register is written;
- the identification word never loses a bit.

The exact stored values need the bench, which compares them against its own model. These include every mask and forced bit, the eight window codes, the reset image and the ignored offsets. The same applies to fault-versus-write collisions and to the rule that reads of other registers leave the interrupt alone.

// File: rtl/xlat_regbank.sv
module xlat_regbank #(
  parameter logic [7:0] IMPL_VER = 8'h41,
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          flt_evt,
  input  logic [31:0]   flt_status,
  input  logic [31:0]   flt_addr,
  output logic [31:0]   win_start,
  output logic          irq
);
  localparam int NSLOT     = 4;
  localparam int IX_CTRL   = 'h0000 >> 2;
  localparam int IX_BASE   = 'h0004 >> 2;
  localparam int IX_TFL    = 'h0014 >> 2;
  localparam int IX_PFL    = 'h0018 >> 2;
  localparam int IX_FSTAT  = 'h1000 >> 2;
  localparam int IX_FADDR  = 'h1004 >> 2;
  localparam int IX_ARB    = 'h1008 >> 2;
  localparam int IX_SLOT0  = 'h1010 >> 2;
  localparam int IX_AEN    = 'h2000 >> 2;
  localparam int IX_ID     = 'h3018 >> 2;
  localparam logic [31:0] VER_WORD = {IMPL_VER, 24'h0};
  localparam logic [31:0] FSTAT_KEEP = 32'hFF0F_FFFF;
  localparam logic [31:0] FSTAT_SET  = 32'h0080_0000;

  logic [31:0] ctrl_q, base_q, tfl_q, pfl_q, fstat_q, faddr_q, arb_q, aen_q, id_q, win_q;
  logic [31:0] slot_q [NSLOT];
  logic        irq_q;

  int idx;
  assign idx = int'(bus_addr[AW-1:2]);

  logic fault_hit;
  assign fault_hit = (idx == IX_FSTAT) || (idx == IX_FADDR);

  assign win_start = win_q;
  assign irq       = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= VER_WORD;
      base_q  <= '0;
      tfl_q   <= '0;
      pfl_q   <= '0;
      fstat_q <= FSTAT_SET;
      faddr_q <= '0;
      arb_q   <= 32'h3;
      aen_q   <= 32'h8;
      id_q    <= 32'h2300_0000;
      win_q   <= '0;
      irq_q   <= 1'b0;
      for (int s = 0; s < NSLOT; s++) slot_q[s] <= '0;
    end else begin
      if (bus_wr) begin
        case (idx)
          IX_CTRL: begin
            ctrl_q <= (bus_wdata & 32'h1D) | VER_WORD;
            win_q  <= 32'hFF00_0000 << bus_wdata[4:2];
          end
          IX_BASE:  base_q  <= bus_wdata & 32'h07FF_FC00;
          IX_TFL:   tfl_q   <= bus_wdata;
          IX_PFL:   pfl_q   <= bus_wdata;
          IX_FSTAT: fstat_q <= (bus_wdata & FSTAT_KEEP) | FSTAT_SET;
          IX_FADDR: faddr_q <= bus_wdata;
          IX_ARB:   arb_q   <= (bus_wdata & 32'h801F_000F) | 32'h1;
          IX_AEN:   aen_q   <= (bus_wdata & 32'h001F_0000) | 32'h8;
          IX_ID:    id_q    <= id_q | (bus_wdata & 32'h00FF_FFFF);
          default: ;
        endcase
        for (int s = 0; s < NSLOT; s++)
          if (idx == IX_SLOT0 + s) slot_q[s] <= bus_wdata & 32'h0001_0003;
      end
      if (flt_evt) begin
        fstat_q <= (flt_status & FSTAT_KEEP) | FSTAT_SET;
        faddr_q <= flt_addr;
        irq_q   <= 1'b1;
      end else if ((bus_wr || bus_rd) && fault_hit) begin
        irq_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (idx)
      IX_CTRL:  bus_rdata = ctrl_q;
      IX_BASE:  bus_rdata = base_q;
      IX_TFL:   bus_rdata = tfl_q;
      IX_PFL:   bus_rdata = pfl_q;
      IX_FSTAT: bus_rdata = fstat_q;
      IX_FADDR: bus_rdata = faddr_q;
      IX_ARB:   bus_rdata = arb_q;
      IX_AEN:   bus_rdata = aen_q;
      IX_ID:    bus_rdata = id_q;
      default: ;
    endcase
    for (int s = 0; s < NSLOT; s++)
      if (idx == IX_SLOT0 + s) bus_rdata = slot_q[s];
  end

  p_fault_sets_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flt_evt |=> irq);

  p_access_clears_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && fault_hit && !flt_evt) |=> !irq);

  p_window_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && idx == IX_CTRL) |=> $stable(win_start));

  p_id_never_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((id_q & $past(id_q)) == $past(id_q)));
endmodule

// File: tb/xlat_regbank_bench.sv
module xlat_regbank_bench;
  localparam logic [7:0] VER = 8'h41;
  localparam int AW = 14;
  localparam int NREG = 13;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, flt_evt = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, flt_status = '0, flt_addr = '0;
  logic [31:0] bus_rdata, win_start;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] mdl [NREG];
  logic [31:0] m_win;
  logic m_irq;

  always #10 clk = ~clk;

  xlat_regbank #(.IMPL_VER(VER), .AW(AW)) u_xlat_regbank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flt_evt(flt_evt), .flt_status(flt_status), .flt_addr(flt_addr),
    .win_start(win_start), .irq(irq));

  function automatic int off_of(int i);
    case (i)
      0: return 'h0;     1: return 'h4;     2: return 'h14;    3: return 'h18;
      4: return 'h1000;  5: return 'h1004;  6: return 'h1008;  7: return 'h1010;
      8: return 'h1014;  9: return 'h1018;  10: return 'h101C; 11: return 'h2000;
      default: return 'h3018;
    endcase
  endfunction

  function automatic logic [31:0] exp_write(int i, logic [31:0] old, logic [31:0] v);
    case (i)
      0: return (v & 32'h1D) | {VER, 24'h0};
      1: return v & 32'h07FF_FC00;
      2, 3, 5: return v;
      4: return (v & 32'hFF0F_FFFF) | 32'h0080_0000;
      6: return (v & 32'h801F_000F) | 32'h1;
      7, 8, 9, 10: return v & 32'h0001_0003;
      11: return (v & 32'h001F_0000) | 32'h8;
      default: return old | (v & 32'h00FF_FFFF);
    endcase
  endfunction

  function automatic string req_of(int i);
    case (i)
      0: return "R2"; 1, 2, 3: return "R4"; 4, 5: return "R5";
      6, 7, 8, 9, 10, 11: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NREG; i++) mdl[i] = '0;
    mdl[0] = {VER, 24'h0}; mdl[4] = 32'h0080_0000; mdl[6] = 32'h3;
    mdl[11] = 32'h8; mdl[12] = 32'h2300_0000;
    m_win = '0; m_irq = 0;
  endtask

  task automatic wr(int off, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = AW'(off); bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(int off, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = AW'(off); #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic mwrite(int i, logic [31:0] d);
    wr(off_of(i), d);
    mdl[i] = exp_write(i, mdl[i], d);
    if (i == 0) m_win = 32'hFF00_0000 << d[4:2];
    if (i == 4 || i == 5) m_irq = 0;
  endtask

  task automatic mread_chk(int i, string req);
    logic [31:0] d;
    rd(off_of(i), d);
    chk(req, d, mdl[i]);
    if (i == 4 || i == 5) m_irq = 0;
  endtask

  task automatic fault(logic [31:0] s, logic [31:0] a);
    @(negedge clk); flt_evt = 1; flt_status = s; flt_addr = a;
    @(negedge clk); flt_evt = 0;
    mdl[4] = (s & 32'hFF0F_FFFF) | 32'h0080_0000; mdl[5] = a; m_irq = 1;
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < NREG; i++) mread_chk(i, req);
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    process::self().srandom(32'h5EED);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 irq", {31'b0, irq}, 0);
    chk("R9 win", win_start, 0);
    sweep("R9");

    // R3 all window codes
    for (int c = 0; c < 8; c++) begin
      mwrite(0, 32'hFFFF_FFE0 | 32'(c << 2) | 32'h1);
      chk("R3 window", win_start, 32'hFF00_0000 << c);
      mread_chk(0, "R2");
    end

    // R1 unimplemented offsets
    wr('h8, 32'hFFFF_FFFF); wr('h1020, 32'hFFFF_FFFF); wr('h2004, 32'hA5A5_A5A5);
    rd('h8, d); chk("R1 unmapped read", d, 0);
    rd('h1020, d); chk("R1 unmapped read", d, 0);
    rd('h3FFC, d); chk("R1 unmapped read", d, 0);
    sweep("R1 no side effect");

    // R10 fault event, R6 read clears
    fault(32'hFFFF_FFFF, 32'hDEAD_B000);
    chk("R10 irq set", {31'b0, irq}, 1);
    mread_chk(1, "R6 other read");
    chk("R6 other read keeps irq", {31'b0, irq}, 1);
    mread_chk(5, "R10 fault addr");
    chk("R6 read clears irq", {31'b0, irq}, 0);
    fault(32'h0000_0001, 32'h1234_5000);
    mread_chk(4, "R10 fault status");
    chk("R6 status read clears irq", {31'b0, irq}, 0);
    fault(32'h4000_0000, 32'h1);
    mwrite(4, 32'h0);
    chk("R5 write clears irq", {31'b0, irq}, 0);

    // R10 collision: write to status with fault pulse
    @(negedge clk); bus_wr = 1; bus_addr = AW'('h1000); bus_wdata = 32'h1111_1111;
    flt_evt = 1; flt_status = 32'h8004_0000; flt_addr = 32'hCAFE_0000;
    @(negedge clk); bus_wr = 0; flt_evt = 0;
    mdl[4] = 32'h8084_0000; mdl[5] = 32'hCAFE_0000; m_irq = 1;
    chk("R10 collision irq", {31'b0, irq}, 1);
    @(negedge clk); bus_rd = 1; bus_addr = AW'('h1004); flt_evt = 1;
    flt_status = 32'h0; flt_addr = 32'h7777_0000;
    @(negedge clk); bus_rd = 0; flt_evt = 0;
    mdl[4] = 32'h0080_0000; mdl[5] = 32'h7777_0000;
    chk("R10 collision read irq", {31'b0, irq}, 1);
    sweep("R10 collision");

    // R8 accumulation
    mwrite(12, 32'hFF00_0001); mwrite(12, 32'h0000_0100);
    mread_chk(12, "R8");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int i = int'($urandom_range(0, NREG - 1));
      int k = int'($urandom_range(0, 9));
      if (k < 6) begin
        mwrite(i, $urandom);
        mread_chk(i, req_of(i));
        if (i == 0) chk("R3 window", win_start, m_win);
      end else if (k < 8) begin
        mread_chk(i, "R6");
      end else begin
        fault($urandom, $urandom);
      end
      chk("R6 irq", {31'b0, irq}, {31'b0, m_irq});
    end
    sweep("R1 final");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule